// File: doc/BRIEF.md
# TDM Sample Serial Port with Control Registers

This block is the serial side of a multichannel sampling front end. It is always the frame master. On every sample event it raises a frame sync and sends a series of 16-bit words, most significant bit first, one bit per bit-clock enable. It sends one word per time slot, with a fixed slot for each of six channels. The port uses a single 16-bit shift register for both directions. The word on the way out is shifted out of the top bit. The word arriving on the serial input is shifted in at the bottom during the same enables. Once the sixteenth bit is in, the word is decoded as a possible control word.

Eight 8-bit configuration registers (index 0 to 7) set the operating mode and which channels are powered. In program mode, a frame carries a single slot and the host can read and write the registers. In data mode, the host input is ignored and only channel samples are sent. In mixed mode, the top bit of every word tells control words (1) apart from data words (0). Samples are then cut to 15 bits, and the host can still program the port. A powered-down channel gives up its slot, and the output enable stays low for those 16 bits.

Top module: `tdm_sport`

## Requirements
- R1: After reset, all eight registers are zero and the port is in program mode. A sample event then gives a frame of a single driven slot carrying 0x0000.
- R2: Each sample event that is accepted raises `fs_out` for exactly one clock cycle, the cycle after the event. This holds in every mode.
- R3: Each slot word leaves MSB first. Its bit 15 is on `sdo` from the clock edge that loads the slot. The following bits are presented after each `bit_en` edge.
- R4: Control word format: bit 15 = 1 (control), bit 14 = 1 read / 0 write, bits 13:11 = device address, bits 10:8 = register index, bits 7:0 = data. In program mode a frame has only slot 0. A write updates the register when its 16th bit is captured. A read is answered in slot 0 of the next frame with {2'b11, device, index, value}.
- R5: Data mode is selected by register 0 bit 0 = 1 with bit 1 = 0. Slot k carries the 16-bit sample of channel k unchanged. Received words have no effect on any register.
- R6: Mixed mode is selected by register 0 bit 1 = 1. A powered channel's slot carries {1'b0, sample[15:1]}. Control words are accepted. A reply or echo goes out in the second slot after the slot that carried the command, or in the next frame if that slot does not exist. The reply is driven even if that slot's channel is off.
- R7: Channel k is on when register 2 bit 0 is set or its own power bit is set. The power bits are register 3 bits 3/7 for channels 0/1, register 4 bits 3/7 for channels 2/3, and register 5 bits 3/7 for channels 4/5. The slot of a channel that is off keeps `sdo_oe` low for all 16 bits.
- R8: While register 1 bit 7 is set, every accepted write word is sent back unchanged, with the timing of R6. The setting in force before the write applies.
- R9: A write with bit 7 set to register 0 clears all registers and aborts the frame. The port then stays idle for four clock cycles and ignores sample events in that time. After that it works in program mode.
- R10: A word whose device address differs from the port's own, or whose bit 15 is 0, is ignored.
- R11: Shifting advances only on `bit_en`. Between enables, `sdo` holds its value.
- R12: A sample event in the middle of a frame restarts the frame at slot 0 with a fresh frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable: one serial bit per asserted cycle |
| sample_evt | input | 1 | Sample event strobe, starts a frame |
| ch_samples | input | NCH*16 | Channel samples, channel k at bits 16k+15:16k |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for `sdo` (low = high impedance) |
| fs_out | output | 1 | Output frame sync |

## Verification
The frame sync is due one clock after the event edge. The MSB of slot 0 is on `sdo` from that same edge, and each later bit appears right after the `bit_en` edge that shifts it. A write changes the slot loads that follow its capture edge, so the bench looks at it only in the next frame. A reply is looked for in slot 0 of the next frame in program mode, and two slots later in mixed mode. The bench drives inputs and samples outputs 2 ns after each rising edge, and reads exactly one bit per enable. For soft reset, the bench checks that the output enable is low one cycle after the capture edge. It checks that a sample event in the next cycle raises no sync, and only then runs a normal frame.

// File: rtl/tdm_sport_pkg.sv
package tdm_sport_pkg;

    localparam int WORD_W = 16;
    localparam int REG_W  = 8;
    localparam int NREG   = 8;
    localparam int IDX_W  = 3;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        MODE_PROG  = 2'd0,
        MODE_DATA  = 2'd1,
        MODE_MIXED = 2'd2
    } port_mode_e;

    typedef struct packed {
        logic             ctl;
        logic             rd;
        logic [2:0]       dev;
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] data;
    } ctl_word_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              drive;
    } slot_load_t;

    function automatic port_mode_e decode_mode(input logic [REG_W-1:0] r0);
        if (r0[1])      return MODE_MIXED;
        else if (r0[0]) return MODE_DATA;
        else            return MODE_PROG;
    endfunction

    function automatic slot_load_t pick_slot_word(
        input port_mode_e        m,
        input logic              rsp_vld,
        input logic [WORD_W-1:0] rsp,
        input logic [WORD_W-1:0] smp,
        input logic              on
    );
        slot_load_t o;
        o.word  = '0;
        o.drive = 1'b0;
        case (m)
            MODE_PROG: begin
                o.drive = 1'b1;
                o.word  = rsp_vld ? rsp : '0;
            end
            MODE_DATA: begin
                o.drive = on;
                o.word  = on ? smp : '0;
            end
            default: begin
                if (rsp_vld) begin
                    o.drive = 1'b1;
                    o.word  = rsp;
                end else begin
                    o.drive = on;
                    o.word  = on ? {1'b0, smp[WORD_W-1:1]} : '0;
                end
            end
        endcase
        return o;
    endfunction

endpackage

// File: rtl/sport_ctl_regs.sv
module sport_ctl_regs
    import tdm_sport_pkg::*;
#(
    parameter int NCH         = 6,
    parameter int SRST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [REG_W-1:0] rd_data,
    output port_mode_e       mode,
    output logic [NCH-1:0]   chan_on,
    output logic             echo_en,
    output logic             busy
);
    localparam int CNT_W     = $clog2(SRST_CYCLES + 1);
    localparam int PWR_BASE  = 3;
    localparam int GLOBAL_RG = 2;
    localparam int ECHO_RG   = 1;

    logic [REG_W-1:0]      regs [NREG];
    logic [CNT_W-1:0]      srst_cnt;
    logic [NREG*REG_W-1:0] regs_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
            srst_cnt <= '0;
        end else if (srst_cnt != '0) begin
            srst_cnt <= srst_cnt - 1'b1;
        end else if (wr_en) begin
            if (wr_idx == '0 && wr_data[REG_W-1]) begin
                for (int i = 0; i < NREG; i++) regs[i] <= '0;
                srst_cnt <= CNT_W'(SRST_CYCLES);
            end else begin
                regs[wr_idx] <= wr_data;
            end
        end
    end

    assign busy    = (srst_cnt != '0);
    assign rd_data = regs[rd_idx];
    assign mode    = decode_mode(regs[0]);
    assign echo_en = regs[ECHO_RG][REG_W-1];

    for (genvar k = 0; k < NCH; k++) begin : g_pwr
        assign chan_on[k] = regs[GLOBAL_RG][0] |
                            regs[PWR_BASE + k/2][3 + 4*(k%2)];
    end

    for (genvar i = 0; i < NREG; i++) begin : g_flat
        assign regs_flat[i*REG_W +: REG_W] = regs[i];
    end

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        busy |-> (regs_flat == '0)) else $error("soft reset left state"); // R9

    AST_SRST_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(busy)) |-> ($past(srst_cnt) == CNT_W'(1))) else $error("idle length"); // R9

endmodule

// File: rtl/sport_slot_seq.sv
module sport_slot_seq
    import tdm_sport_pkg::*;
#(
    parameter int NCH = 6,
    localparam int SLOT_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              sample_evt,
    input  logic              bit_en,
    input  logic              single_slot,
    output logic              active,
    output logic              shift_en,
    output logic              last_bit,
    output logic              load_en,
    output logic [SLOT_W-1:0] load_slot,
    output logic              fs_out
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NCH - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;
    logic              more_slots;

    assign shift_en   = active && bit_en && !sample_evt && !clr;
    assign last_bit   = shift_en && (bit_q == LAST_BIT);
    assign more_slots = !single_slot && (slot_q != LAST_SLOT);
    assign load_en    = !clr && (sample_evt || (last_bit && more_slots));
    assign load_slot  = sample_evt ? '0 : SLOT_W'(slot_q + 1'b1);

    always_ff @(posedge clk) begin
        if (clr) begin
            active <= 1'b0;
            slot_q <= '0;
            bit_q  <= '0;
            fs_out <= 1'b0;
        end else begin
            fs_out <= sample_evt;
            if (sample_evt) begin
                active <= 1'b1;
                slot_q <= '0;
                bit_q  <= '0;
            end else if (shift_en) begin
                if (bit_q == LAST_BIT) begin
                    bit_q <= '0;
                    if (more_slots) slot_q <= slot_q + 1'b1;
                    else            active <= 1'b0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        active |-> (slot_q <= LAST_SLOT)) else $error("slot overrun"); // R7

    AST_FS_FOLLOWS_EVT: assert property (@(posedge clk) disable iff (rst)
        (sample_evt && !clr) |=> fs_out) else $error("missing sync"); // R2

    AST_FS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (fs_out && !$past(sample_evt)) |-> 1'b0) else $error("stray sync"); // R2

endmodule

// File: rtl/sport_shift_reg.sv
module sport_shift_reg
    import tdm_sport_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              load_en,
    input  slot_load_t        load_val,
    input  logic              shift_en,
    input  logic              sdi,
    output logic              msb,
    output logic              drive,
    output logic [WORD_W-1:0] cap_word
);
    logic [WORD_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            sr_q  <= '0;
            drive <= 1'b0;
        end else if (load_en) begin
            sr_q  <= load_val.word;
            drive <= load_val.drive;
        end else if (shift_en) begin
            sr_q  <= {sr_q[WORD_W-2:0], sdi};
        end
    end

    assign msb      = sr_q[WORD_W-1];
    assign cap_word = {sr_q[WORD_W-2:0], sdi};

endmodule

// File: rtl/tdm_sport.sv
module tdm_sport
    import tdm_sport_pkg::*;
#(
    parameter int          NCH         = 6,
    parameter logic [2:0]  DEV_ADDR    = 3'd0,
    parameter int          SRST_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_en,
    input  logic                  sample_evt,
    input  logic [NCH*WORD_W-1:0] ch_samples,
    input  logic                  sdi,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic                  fs_out
);
    localparam int SLOT_W = (NCH > 1) ? $clog2(NCH) : 1;

    port_mode_e        mode;
    logic [NCH-1:0]    chan_on;
    logic              echo_en, busy, clr;
    logic              active, shift_en, last_bit, load_en, drive, msb;
    logic [SLOT_W-1:0] load_slot;
    logic [WORD_W-1:0] cap_word, rsp_word, cur_smp;
    logic              rsp_vld;
    logic [REG_W-1:0]  rd_data;
    ctl_word_t         cw;
    logic              accept, wr_en, want_rsp;
    slot_load_t        load_val;

    assign clr = rst || busy;
    assign cw  = ctl_word_t'(cap_word);

    assign accept   = last_bit && (mode != MODE_DATA) && cw.ctl && (cw.dev == DEV_ADDR);
    assign wr_en    = accept && !cw.rd;
    assign want_rsp = accept && (cw.rd || echo_en);

    sport_ctl_regs #(.NCH(NCH), .SRST_CYCLES(SRST_CYCLES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (cw.idx),
        .wr_data (cw.data),
        .rd_idx  (cw.idx),
        .rd_data (rd_data),
        .mode    (mode),
        .chan_on (chan_on),
        .echo_en (echo_en),
        .busy    (busy)
    );

    sport_slot_seq #(.NCH(NCH)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .sample_evt  (sample_evt),
        .bit_en      (bit_en),
        .single_slot (mode == MODE_PROG),
        .active      (active),
        .shift_en    (shift_en),
        .last_bit    (last_bit),
        .load_en     (load_en),
        .load_slot   (load_slot),
        .fs_out      (fs_out)
    );

    assign cur_smp  = ch_samples[int'(load_slot)*WORD_W +: WORD_W];
    assign load_val = pick_slot_word(mode, rsp_vld, rsp_word, cur_smp, chan_on[load_slot]);

    sport_shift_reg u_sr (
        .clk      (clk),
        .clr      (clr),
        .load_en  (load_en),
        .load_val (load_val),
        .shift_en (shift_en),
        .sdi      (sdi),
        .msb      (msb),
        .drive    (drive),
        .cap_word (cap_word)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            rsp_vld  <= 1'b0;
            rsp_word <= '0;
        end else if (want_rsp) begin
            rsp_vld  <= 1'b1;
            rsp_word <= cw.rd ? {2'b11, cw.dev, cw.idx, rd_data} : cap_word;
        end else if (load_en) begin
            rsp_vld  <= 1'b0;
        end
    end

    assign sdo_oe = active && drive;
    assign sdo    = sdo_oe && msb;

    AST_DATA_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DATA && !busy) |=> $stable({mode, chan_on, echo_en})) else $error("data mode write"); // R5

    AST_OFF_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (load_en && mode == MODE_DATA && !chan_on[load_slot]) |=> !sdo_oe) else $error("off slot driven"); // R7

    AST_MIXED_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (load_en && mode == MODE_MIXED && !rsp_vld && chan_on[load_slot]) |=> (sdo_oe && !sdo)) else $error("flag bit"); // R6

    AST_READ_QUEUED: assert property (@(posedge clk) disable iff (rst)
        (accept && cw.rd) |=> rsp_vld) else $error("reply lost"); // R4

    AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (active && !bit_en && !sample_evt && !busy) |=> $stable(sdo)) else $error("sdo moved"); // R11

endmodule

// File: tb/tdm_sport_tb.sv
module tdm_sport_tb_top;
    localparam int NCH = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic sample_evt = 1'b0;
    logic sdi = 1'b0;
    logic [NCH*16-1:0] ch_samples;
    logic sdo, sdo_oe, fs_out;

    logic [15:0] smp  [NCH];
    logic [15:0] tx_w [NCH];
    logic [15:0] got_w [NCH];
    int          got_oe [NCH];
    logic        got_fs;
    int          stab_err;
    int          n_chk = 0;
    int          n_err = 0;

    always #4 clk = ~clk;

    for (genvar k = 0; k < NCH; k++) begin : g_smp
        assign ch_samples[k*16 +: 16] = smp[k];
    end

    tdm_sport #(.NCH(NCH)) dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .sample_evt(sample_evt),
        .ch_samples(ch_samples), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .fs_out(fs_out)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] wr(input logic [2:0] a, input logic [7:0] d);
        return {1'b1, 1'b0, 3'b000, a, d};
    endfunction

    function automatic logic [15:0] rd(input logic [2:0] a);
        return {2'b11, 3'b000, a, 8'h00};
    endfunction

    function automatic logic [15:0] mix(input logic [15:0] s);
        return {1'b0, s[15:1]};
    endfunction

    task automatic clear_tx();
        for (int k = 0; k < NCH; k++) tx_w[k] = 16'h0000;
    endtask

    task automatic hw_reset();
        rst = 1'b1;
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic run_period(input int gap);
        logic [15:0] w;
        int hi, lo;
        logic prev;
        stab_err = 0;
        sample_evt = 1'b1;
        tick();
        sample_evt = 1'b0;
        got_fs = fs_out;
        for (int s = 0; s < NCH; s++) begin
            w = '0; hi = 0; lo = 0;
            for (int b = 0; b < 16; b++) begin
                w[15-b] = sdo;
                if (sdo_oe) hi++; else lo++;
                sdi = tx_w[s][15-b];
                bit_en = 1'b1;
                tick();
                bit_en = 1'b0;
                for (int g = 0; g < gap; g++) begin
                    prev = sdo;
                    tick();
                    if (sdo !== prev) stab_err++;
                end
            end
            got_w[s]  = w;
            got_oe[s] = (lo == 0) ? 1 : ((hi == 0) ? 0 : 2);
        end
        sdi = 1'b0;
        tick();
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int b = 0; b < 16; b++) begin
            sdi = w[15-b];
            bit_en = 1'b1;
            tick();
        end
        bit_en = 1'b0;
        sdi = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog got=hang exp=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < NCH; k++) smp[k] = 16'h0000;
        clear_tx();
        hw_reset();

        // R1 / R2 / R4: reset frame
        run_period(0);
        check("R2 sync after reset", 32'(got_fs), 32'd1);
        check("R1 slot0 driven", 32'(got_oe[0]), 32'd1);
        check("R1 slot0 word", 32'(got_w[0]), 32'h0000);
        for (int k = 1; k < NCH; k++) check("R4 single slot", 32'(got_oe[k]), 32'd0);

        // R4: program writes and readback
        tx_w[0] = wr(3'd3, 8'h88); run_period(0);
        tx_w[0] = wr(3'd4, 8'h08); run_period(0);
        tx_w[0] = wr(3'd5, 8'h80); run_period(0);
        tx_w[0] = rd(3'd3);        run_period(0);
        check("R4 no reply yet", 32'(got_w[0]), 32'h0000);
        tx_w[0] = 16'h0000;        run_period(0);
        check("R4 read D", 32'(got_w[0]), 32'hC388);
        check("R3 msb first driven", 32'(got_oe[0]), 32'd1);

        // R10: foreign address and unflagged word ignored
        tx_w[0] = {1'b1, 1'b0, 3'b011, 3'd2, 8'h01}; run_period(0);
        tx_w[0] = 16'h0201; run_period(0);
        tx_w[0] = rd(3'd2); run_period(0);
        tx_w[0] = 16'h0000; run_period(0);
        check("R10 reg2 untouched", 32'(got_w[0]), 32'hC200);

        // R5 / R7: data mode, channels 0,1,2,5 powered
        smp[0] = 16'h7FFF; smp[1] = 16'h8001; smp[2] = 16'h1234;
        smp[3] = 16'h5A5A; smp[4] = 16'hF00F; smp[5] = 16'hA5C3;
        tx_w[0] = wr(3'd0, 8'h01); run_period(0);
        tx_w[0] = wr(3'd2, 8'h01); run_period(0);
        check("R2 sync data mode", 32'(got_fs), 32'd1);
        for (int k = 0; k < NCH; k++) begin
            if (k == 3 || k == 4) begin
                check("R7 off slot quiet", 32'(got_oe[k]), 32'd0);
            end else begin
                check("R7 on slot driven", 32'(got_oe[k]), 32'd1);
                check("R5 full sample", 32'(got_w[k]), 32'(smp[k]));
            end
        end
        tx_w[0] = 16'h0000; run_period(0);
        check("R5 write ignored ch3", 32'(got_oe[3]), 32'd0);
        check("R5 write ignored ch4", 32'(got_oe[4]), 32'd0);
        check("R5 ch5 sample", 32'(got_w[5]), 32'(smp[5]));

        // R6 / R7: mixed mode power sweep
        hw_reset();
        clear_tx();
        tx_w[0] = wr(3'd0, 8'h02); run_period(0);
        for (int m = 0; m < 64; m++) begin
            logic [5:0] mb;
            mb = 6'(m);
            clear_tx();
            tx_w[0] = wr(3'd3, {mb[1], 3'b000, mb[0], 3'b000});
            tx_w[1] = wr(3'd4, {mb[3], 3'b000, mb[2], 3'b000});
            tx_w[2] = wr(3'd5, {mb[5], 3'b000, mb[4], 3'b000});
            run_period(0);
            for (int k = 0; k < NCH; k++) smp[k] = 16'(m * 16'h0713 + k * 16'h3C5B + 1);
            clear_tx();
            run_period(0);
            for (int k = 0; k < NCH; k++) begin
                check("R7 power sweep oe", 32'(got_oe[k]), 32'(mb[k]));
                if (mb[k]) check("R6 mixed data word", 32'(got_w[k]), 32'(mix(smp[k])));
            end
        end

        // R6 / R7: global power and read reply two slots later
        smp[0] = 16'hC001; smp[1] = 16'h3FFE; smp[2] = 16'h1111;
        smp[3] = 16'h8765; smp[4] = 16'h0F0F; smp[5] = 16'hFFFF;
        clear_tx();
        tx_w[0] = wr(3'd3, 8'h00); tx_w[1] = wr(3'd4, 8'h00); tx_w[2] = wr(3'd5, 8'h00);
        run_period(0);
        clear_tx();
        tx_w[0] = wr(3'd2, 8'h01); run_period(0);
        clear_tx();
        tx_w[0] = rd(3'd2); run_period(0);
        check("R6 slot1 data", 32'(got_w[1]), 32'(mix(smp[1])));
        check("R6 reply slot2", 32'(got_w[2]), 32'hC201);
        check("R6 reply driven", 32'(got_oe[2]), 32'd1);
        for (int k = 0; k < NCH; k++) check("R7 global on", 32'(got_oe[k]), 32'd1);
        check("R6 slot5 flag", 32'(got_w[5]), 32'(mix(smp[5])));

        // R8: echo enable, then echoed write
        clear_tx();
        tx_w[0] = wr(3'd1, 8'h80);
        tx_w[1] = wr(3'd3, 8'h00);
        run_period(0);
        check("R8 no echo before enable", 32'(got_w[2]), 32'(mix(smp[2])));
        check("R8 echo word", 32'(got_w[3]), 32'h8300);
        check("R8 after echo", 32'(got_w[4]), 32'(mix(smp[4])));

        // R11: gaps between bit enables
        clear_tx();
        run_period(3);
        check("R11 sdo stable", 32'(stab_err), 32'd0);
        check("R11 slot0 gapped", 32'(got_w[0]), 32'(mix(smp[0])));
        check("R11 slot3 gapped", 32'(got_w[3]), 32'(mix(smp[3])));

        // R12: restart mid-frame
        sample_evt = 1'b1; tick(); sample_evt = 1'b0;
        for (int b = 0; b < 20; b++) begin
            bit_en = 1'b1; tick();
        end
        bit_en = 1'b0;
        run_period(0);
        check("R12 fresh sync", 32'(got_fs), 32'd1);
        check("R12 slot0", 32'(got_w[0]), 32'(mix(smp[0])));
        check("R12 slot5", 32'(got_w[5]), 32'(mix(smp[5])));

        // R9: soft reset
        sample_evt = 1'b1; tick(); sample_evt = 1'b0;
        shift_word(wr(3'd0, 8'h80));
        tick();
        check("R9 frame aborted", 32'(sdo_oe), 32'd0);
        sample_evt = 1'b1; tick(); sample_evt = 1'b0;
        check("R9 event ignored", 32'(fs_out), 32'd0);
        for (int i = 0; i < 6; i++) tick();
        clear_tx();
        run_period(0);
        check("R9 program slot0", 32'(got_oe[0]), 32'd1);
        check("R9 single slot", 32'(got_oe[1]), 32'd0);
        check("R9 zero word", 32'(got_w[0]), 32'h0000);
        tx_w[0] = rd(3'd2); run_period(0);
        tx_w[0] = 16'h0000; run_period(0);
        check("R9 reg2 cleared", 32'(got_w[0]), 32'hC200);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule